// File: doc/BRIEF.md
# Non-Zero Activation Scan and Broadcast Unit

This block holds an input activation vector spread across a set of lane buffers. In its computing mode it walks that vector one window at a time and sends every non-zero element, with its position in the vector, to all downstream processing lanes. A window is one buffer slot taken across every lane. A tree of 4-way leading-non-zero detectors picks the lowest-indexed live element in the current window. Once an element has been sent it is masked out, so the tree offers the next one on the following cycle. When a window has nothing left to send, the scan moves to the next window.

The block has two modes. In I/O mode the unit is idle, and an external port may write and read the buffers. A start pulse, accepted only in I/O mode, does three things: it latches the vector length for the layer, it latches a column-pointer base, and it enters computing mode. The broadcast is held whenever any consumer lane reports its queue full. The scan ends with a done pulse once no non-zero element is left below the programmed length, and the unit then returns to I/O mode. Running a different layer only needs a new length and pointer base with the next start.

Top module: `nzb_top`

## Requirements
- R1: After reset the unit is in I/O mode (busy low), bc_valid and done are low, and every buffer word reads zero.
- R2: While busy is low, wr_en stores wr_data at wr_addr. rd_data always shows the word at rd_addr in the same cycle. Address a belongs to lane a mod LANES and slot a div LANES.
- R3: A start seen while busy is low latches length and ptr_base, and busy is high from the next cycle on. A start seen while busy is high is ignored: the scan goes on under the length it already has.
- R4: During a scan, every non-zero element with index below the length is broadcast exactly once. Broadcasts come in strictly ascending index order, with bc_value equal to the element and bc_index equal to its address. Zero elements are never broadcast.
- R5: Each unstalled busy cycle does exactly one thing. It broadcasts the lowest unsent live element of the current window, or, if there is none, it either moves to the next window or ends the scan. A window holding k live elements therefore costs k+1 unstalled cycles, except the final window, which costs k+1 cycles including the done cycle.
- R6: In any cycle where at least one bit of lane_full is high, bc_valid and done are low and the scan does not advance.
- R7: done is high for exactly one cycle: the unstalled busy cycle in which the last window has no live element left. busy is low from the next cycle. With length 0 this is the first busy cycle.
- R8: While busy is high, wr_en has no effect on the buffer contents.
- R9: bc_ptr equals the latched ptr_base plus bc_index, modulo 2^PW.
- R10: Elements at index greater than or equal to the latched length are never broadcast, even if they are non-zero. A length above LANES*DEPTH acts as LANES*DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe (I/O mode only) |
| wr_addr | input | AW | Buffer write address |
| wr_data | input | DW | Buffer write data |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | DW | Buffer read data |
| start | input | 1 | Begin a scan (I/O mode only) |
| length | input | LENW | Number of vector elements to scan |
| ptr_base | input | PW | Column-pointer base for this layer |
| lane_full | input | LANES | Per-lane queue-full flags |
| busy | output | 1 | High in computing mode |
| bc_valid | output | 1 | Broadcast present this cycle |
| bc_value | output | DW | Broadcast activation value |
| bc_index | output | AW | Broadcast element index |
| bc_ptr | output | PW | ptr_base plus index |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The hardest situation to reach from the ports is a queue-full stall that lands exactly on a window change or on the final done cycle. In those cycles a late advance or a stray done pulse would show up only as a timing shift. The bench therefore drives lane_full with random single-lane hits during scans over vectors that mix empty windows, fully dense windows and elements on either side of a short length. A cycle-level model, compared on every clock, catches any advance or pulse taken during a stall.

// File: rtl/nzb_pkg.sv
package nzb_pkg;
   typedef enum logic {
      MODE_IO  = 1'b0,
      MODE_RUN = 1'b1
   } nzb_mode_e;
endpackage

// File: rtl/nzb_lnzd_node.sv
// One 4-way leading-non-zero selector: the lowest-numbered child with a hit wins.
module nzb_lnzd_node #(
   parameter int DW = 16,
   parameter int IW = 4
) (
   input  logic          c_found [4],
   input  logic [DW-1:0] c_val   [4],
   input  logic [IW-1:0] c_idx   [4],
   output logic          o_found,
   output logic [DW-1:0] o_val,
   output logic [IW-1:0] o_idx
);
   always_comb begin
      o_found = 1'b0;
      o_val   = '0;
      o_idx   = '0;
      for (int c = 3; c >= 0; c--) begin
         if (c_found[c]) begin
            o_found = 1'b1;
            o_val   = c_val[c];
            o_idx   = c_idx[c];
         end
      end
   end
endmodule

// File: rtl/nzb_lnzd_tree.sv
// Quadtree of 4-way selectors over LANES leaves; nodes stored in one flat array.
module nzb_lnzd_tree #(
   parameter int LANES = 16,
   parameter int DW    = 16,
   localparam int IW   = $clog2(LANES)
) (
   input  logic          leaf_ok  [LANES],
   input  logic [DW-1:0] leaf_val [LANES],
   output logic          found,
   output logic [DW-1:0] val,
   output logic [IW-1:0] idx
);
   localparam int LEVELS = $clog2(LANES) / 2;
   localparam int TOT    = LANES + (LANES - 1) / 3;

   function automatic int lvl_base(input int lv);
      int b;
      b = LANES;
      for (int k = 0; k < lv; k++) b += LANES >> (2 * (k + 1));
      return b;
   endfunction

   if (LEVELS < 1 || (1 << (2 * LEVELS)) != LANES) begin : g_bad_lanes
      $error("nzb_lnzd_tree: LANES must be a power of 4, at least 4");
   end

   logic          nf [TOT];
   logic [DW-1:0] nv [TOT];
   logic [IW-1:0] ni [TOT];

   for (genvar l = 0; l < LANES; l++) begin : g_leaf
      assign nf[l] = leaf_ok[l];
      assign nv[l] = leaf_val[l];
      assign ni[l] = IW'(l);
   end

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      localparam int CNT = LANES >> (2 * (lv + 1));
      localparam int OB  = lvl_base(lv);
      localparam int IB  = (lv == 0) ? 0 : lvl_base(lv - 1);
      for (genvar n = 0; n < CNT; n++) begin : g_node
         logic          cf [4];
         logic [DW-1:0] cv [4];
         logic [IW-1:0] ci [4];
         for (genvar c = 0; c < 4; c++) begin : g_ch
            assign cf[c] = nf[IB + 4 * n + c];
            assign cv[c] = nv[IB + 4 * n + c];
            assign ci[c] = ni[IB + 4 * n + c];
         end
         nzb_lnzd_node #(.DW(DW), .IW(IW)) u_node (
            .c_found (cf),
            .c_val   (cv),
            .c_idx   (ci),
            .o_found (nf[OB + n]),
            .o_val   (nv[OB + n]),
            .o_idx   (ni[OB + n])
         );
      end
   end

   assign found = nf[TOT-1];
   assign val   = nv[TOT-1];
   assign idx   = ni[TOT-1];
endmodule

// File: rtl/nzb_act_buf.sv
// Activation store: external write/read port plus a full-width window read.
module nzb_act_buf #(
   parameter int LANES = 16,
   parameter int DEPTH = 4,
   parameter int DW    = 16,
   localparam int N    = LANES * DEPTH,
   localparam int AW   = $clog2(N),
   localparam int WW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          io_open,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic [WW-1:0] win,
   output logic [DW-1:0] win_val [LANES]
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("nzb_act_buf: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
      end else if (io_open && wr_en && (int'(wr_addr) < N)) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = (int'(rd_addr) < N) ? mem[rd_addr] : '0;

   for (genvar l = 0; l < LANES; l++) begin : g_win
      localparam int IW = $clog2(LANES);
      logic [AW-1:0] a;
      assign a          = {win, IW'(l)};
      assign win_val[l] = (int'(a) < N) ? mem[a] : '0;
   end

   // R8: a write strobe outside I/O mode leaves the addressed word unchanged
   p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_open && wr_en && (int'(wr_addr) < N)) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
endmodule

// File: rtl/nzb_ctrl.sv
// Mode FSM, window counter, sent-mask and latched layer settings.
module nzb_ctrl
   import nzb_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DEPTH = 4,
   parameter int PW    = 16,
   localparam int N    = LANES * DEPTH,
   localparam int IW   = $clog2(LANES),
   localparam int WW   = $clog2(DEPTH),
   localparam int LENW = $clog2(N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LENW-1:0]  length,
   input  logic [PW-1:0]    ptr_base,
   input  logic             any_full,
   input  logic             found,
   input  logic [IW-1:0]    sel_lane,
   output logic             busy,
   output logic [WW-1:0]    win,
   output logic [LANES-1:0] mask,
   output logic [LENW-1:0]  len_q,
   output logic [PW-1:0]    ptr_q,
   output logic             fire,
   output logic             done
);
   nzb_mode_e     mode;
   logic          last;
   logic [LENW:0] nxt_base;

   assign nxt_base = ((LENW + 1)'(win) + 1'b1) << IW;
   assign last     = (int'(win) == DEPTH - 1) || (nxt_base >= {1'b0, len_q});
   assign busy     = (mode == MODE_RUN);
   assign fire     = busy && !any_full && found;
   assign done     = busy && !any_full && !found && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= MODE_IO;
         win   <= '0;
         mask  <= '0;
         len_q <= '0;
         ptr_q <= '0;
      end else begin
         unique case (mode)
            MODE_IO: if (start) begin
               mode  <= MODE_RUN;
               win   <= '0;
               mask  <= '0;
               len_q <= length;
               ptr_q <= ptr_base;
            end
            MODE_RUN: if (!any_full) begin
               if (found) begin
                  mask[sel_lane] <= 1'b1;
               end else if (last) begin
                  mode <= MODE_IO;
               end else begin
                  win  <= win + 1'b1;
                  mask <= '0;
               end
            end
            default: mode <= MODE_IO;
         endcase
      end
   end

   // R7: the end pulse always hands control back to I/O mode
   p_done_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R6: a stalled cycle freezes the window and the sent-mask
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && any_full) |=> ($stable(win) && $stable(mask)));
   // R3: a start during a scan does not reload the layer settings
   p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy && $stable(len_q) && $stable(ptr_q)));
endmodule

// File: rtl/nzb_top.sv
module nzb_top #(
   parameter int LANES = 16,
   parameter int DEPTH = 4,
   parameter int DW    = 16,
   parameter int PW    = 16,
   localparam int N    = LANES * DEPTH,
   localparam int AW   = $clog2(N),
   localparam int IW   = $clog2(LANES),
   localparam int WW   = $clog2(DEPTH),
   localparam int LENW = $clog2(N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic             start,
   input  logic [LENW-1:0]  length,
   input  logic [PW-1:0]    ptr_base,
   input  logic [LANES-1:0] lane_full,
   output logic             busy,
   output logic             bc_valid,
   output logic [DW-1:0]    bc_value,
   output logic [AW-1:0]    bc_index,
   output logic [PW-1:0]    bc_ptr,
   output logic             done
);
   if (PW < AW) begin : g_bad_pw
      $error("nzb_top: PW must be at least the index width");
   end

   logic [WW-1:0]    win;
   logic [LANES-1:0] mask;
   logic [LENW-1:0]  len_q;
   logic [PW-1:0]    ptr_q;
   logic [DW-1:0]    win_val [LANES];
   logic             leaf_ok [LANES];
   logic             found;
   logic [DW-1:0]    sel_val;
   logic [IW-1:0]    sel_lane;
   logic             fire;

   nzb_act_buf #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_open (!busy),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .win     (win),
      .win_val (win_val)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_qual
      logic [AW-1:0] eidx;
      assign eidx       = {win, IW'(l)};
      assign leaf_ok[l] = (win_val[l] != '0) && !mask[l]
                          && ((LENW + 1)'(eidx) < (LENW + 1)'(len_q));
   end

   nzb_lnzd_tree #(.LANES(LANES), .DW(DW)) u_tree (
      .leaf_ok  (leaf_ok),
      .leaf_val (win_val),
      .found    (found),
      .val      (sel_val),
      .idx      (sel_lane)
   );

   nzb_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PW(PW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .length   (length),
      .ptr_base (ptr_base),
      .any_full (|lane_full),
      .found    (found),
      .sel_lane (sel_lane),
      .busy     (busy),
      .win      (win),
      .mask     (mask),
      .len_q    (len_q),
      .ptr_q    (ptr_q),
      .fire     (fire),
      .done     (done)
   );

   assign bc_valid = fire;
   assign bc_value = sel_val;
   assign bc_index = {win, sel_lane};
   assign bc_ptr   = ptr_q + PW'(bc_index);

   // Order tracking for the ascending-index property
   logic          seen;
   logic [AW-1:0] last_idx;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         last_idx <= '0;
      end else if (!busy) begin
         seen <= 1'b0;
      end else if (bc_valid) begin
         seen     <= 1'b1;
         last_idx <= bc_index;
      end
   end

   // R4: nothing but non-zero data leaves on the broadcast
   p_fire_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |-> (bc_value != '0));
   // R4: indices within one scan strictly ascend
   p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && seen) |-> (bc_index > last_idx));
   // R10: nothing at or beyond the latched length is sent
   p_idx_below_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |-> ((LENW + 1)'(bc_index) < (LENW + 1)'(len_q)));
   // R6: a full queue anywhere blocks both broadcast and end pulse
   p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_full) |-> !(bc_valid || done));
endmodule

// File: tb/nzb_top_tb.sv
module nzb_top_tb;
   localparam int LANES = 16;
   localparam int DEPTH = 4;
   localparam int DW    = 16;
   localparam int PW    = 16;
   localparam int N     = LANES * DEPTH;
   localparam int AW    = $clog2(N);
   localparam int LENW  = $clog2(N + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_addr = '0;
   logic [DW-1:0]    wr_data = '0;
   logic [AW-1:0]    rd_addr = '0;
   logic [DW-1:0]    rd_data;
   logic             start = 1'b0;
   logic [LENW-1:0]  length = '0;
   logic [PW-1:0]    ptr_base = '0;
   logic [LANES-1:0] lane_full = '0;
   logic             busy, bc_valid, done;
   logic [DW-1:0]    bc_value;
   logic [AW-1:0]    bc_index;
   logic [PW-1:0]    bc_ptr;

   nzb_top #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .PW(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .length(length),
      .ptr_base(ptr_base), .lane_full(lane_full), .busy(busy), .bc_valid(bc_valid),
      .bc_value(bc_value), .bc_index(bc_index), .bc_ptr(bc_ptr), .done(done)
   );

   always #10 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int done_seen = 0;
   int bc_seen = 0;
   bit stall_en = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int mem_m [N];
   bit sent  [N];
   bit busy_m;
   int win_m, len_m, ptr_m;

   function automatic void model_eval(output bit v, output int idx, output bit dn);
      v = 0; idx = 0; dn = 0;
      if (busy_m && lane_full == '0) begin
         for (int l = 0; l < LANES; l++) begin
            int i;
            i = win_m * LANES + l;
            if (!v && i < len_m && mem_m[i] != 0 && !sent[i]) begin
               v = 1; idx = i;
            end
         end
         if (!v) dn = (win_m == DEPTH - 1) || ((win_m + 1) * LANES >= len_m);
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m = 0; win_m = 0; len_m = 0; ptr_m = 0;
         for (int i = 0; i < N; i++) begin mem_m[i] = 0; sent[i] = 0; end
      end else if (busy_m) begin
         bit v, dn; int idx;
         model_eval(v, idx, dn);
         if (v) sent[idx] = 1;
         else if (lane_full == '0) begin
            if (dn) busy_m = 0;
            else win_m++;
         end
      end else begin
         if (wr_en) mem_m[wr_addr] = wr_data;
         if (start) begin
            busy_m = 1; win_m = 0;
            len_m = (length > N) ? N : int'(length);
            ptr_m = ptr_base;
            for (int i = 0; i < N; i++) sent[i] = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit v, dn; int idx;
         model_eval(v, idx, dn);
         chk(busy == busy_m, "R3 busy", busy, busy_m);
         chk(bc_valid == v, (lane_full != 0) ? "R6 bc_valid" : "R5 bc_valid", bc_valid, v);
         chk(done == dn, "R7 done", done, dn);
         if (v && bc_valid) begin
            chk(int'(bc_index) == idx, "R4 bc_index", bc_index, idx);
            chk(int'(bc_value) == mem_m[idx], "R4 bc_value", bc_value, mem_m[idx]);
            chk(int'(bc_ptr) == ((ptr_m + idx) & 16'hFFFF), "R9 bc_ptr", bc_ptr,
                (ptr_m + idx) & 16'hFFFF);
         end
         if (bc_valid) bc_seen++;
         if (done) done_seen++;
      end
   end

   // queue-full stimulus (single driver)
   always @(posedge clk) begin
      #1;
      if (stall_en && ($urandom % 3 == 0)) lane_full = LANES'(1) << ($urandom % LANES);
      else lane_full = '0;
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   // ---------------- drivers ----------------
   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      rd_addr = AW'(a);
      @(negedge clk);
      chk(int'(rd_data) == exp, req, rd_data, exp);
   endtask

   task automatic go(input int len, input int pb);
      @(posedge clk); #1;
      start = 1; length = LENW'(len); ptr_base = PW'(pb);
      @(posedge clk); #1;
      start = 0;
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic clear_all();
      for (int i = 0; i < N; i++) wr(i, 0);
   endtask

   function automatic int count_live(input int len);
      int c = 0;
      for (int i = 0; i < N && i < len; i++) if (mem_m[i] != 0) c++;
      return c;
   endfunction

   initial begin
      int before_bc, before_done, exp_bc;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(busy == 0, "R1 busy after reset", busy, 0);
      chk(bc_valid == 0 && done == 0, "R1 outputs idle", bc_valid, 0);
      rd_chk(7, 0, "R1 buffer zero");
      rst_n = 1;
      @(negedge clk);
      rd_chk(37, 0, "R1 buffer zero after release");

      // Pattern A: edges of lanes, an empty window, a dense tail
      wr(0, 16'h0011); wr(3, 16'h8000); wr(15, 16'h0123); wr(16, 16'hFFFF);
      for (int i = 48; i < 64; i++) wr(i, i * 3 + 1);
      rd_chk(15, 16'h0123, "R2 readback lane 15");
      rd_chk(16, 16'hFFFF, "R2 readback slot 1");
      rd_chk(50, 151, "R2 readback dense");

      // full-length scan
      before_bc = bc_seen; before_done = done_seen;
      exp_bc = count_live(N);
      go(N, 16'h0100);
      chk(bc_seen - before_bc == exp_bc, "R4 broadcast count", bc_seen - before_bc, exp_bc);
      chk(done_seen - before_done == 1, "R7 one done pulse", done_seen - before_done, 1);

      // R3: start during a scan is ignored; R8: write during scan is ignored
      @(posedge clk); #1;
      start = 1; length = LENW'(N); ptr_base = '0;
      @(posedge clk); #1;
      start = 1; length = LENW'(2);
      wr_en = 1; wr_addr = AW'(3); wr_data = 16'h5555;
      @(posedge clk); #1;
      start = 0; wr_en = 0;
      for (int k = 0; k < 500; k++) begin @(negedge clk); if (!busy) break; end
      rd_chk(3, 16'h8000, "R8 write while busy ignored");

      // R10: short length cuts off non-zero tail
      before_bc = bc_seen;
      exp_bc = count_live(21);
      go(21, 0);
      chk(bc_seen - before_bc == exp_bc, "R10 count below length", bc_seen - before_bc, exp_bc);

      // R7: zero length ends immediately
      before_bc = bc_seen; before_done = done_seen;
      go(0, 0);
      chk(bc_seen - before_bc == 0, "R7 length 0 no broadcast", bc_seen - before_bc, 0);
      chk(done_seen - before_done == 1, "R7 length 0 done", done_seen - before_done, 1);

      // R9: pointer wrap
      go(N, 16'hFFF8);

      // R6: stalls over mixed pattern
      stall_en = 1;
      for (int r = 0; r < 4; r++) begin
         before_bc = bc_seen;
         exp_bc = count_live(N - r * 9);
         go(N - r * 9, r * 1000);
         chk(bc_seen - before_bc == exp_bc, "R6 count under stalls", bc_seen - before_bc, exp_bc);
      end
      stall_en = 0;

      // Pattern B: all dense, then random sparse
      for (int i = 0; i < N; i++) wr(i, i + 1);
      go(N, 0);
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < N; i++) wr(i, ($urandom % 4 == 0) ? ($urandom % 65535 + 1) : 0);
         stall_en = (r % 2 == 1);
         before_bc = bc_seen;
         exp_bc = count_live(N - r * 5);
         go(N - r * 5, $urandom % 65536);
         chk(bc_seen - before_bc == exp_bc, "R5 sparse count", bc_seen - before_bc, exp_bc);
      end
      stall_en = 0;
      clear_all();
      go(N, 0);

      repeat (3) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule